// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides how deeply the processor sleeps when it runs a stop command. Software first writes a 2-bit selector into a small control register. Later, a one-cycle stop strobe moves the controller from run into one of three sleep states: wait, doze or stop. The selector value held in the register at the moment of the strobe picks the state.

Each sleep state drives three clock enables in its own way:

- the CPU/memory clock enable;
- the enable for peripheral group A, which halts in doze;
- the enable for peripheral group B, which keeps running in doze.

Interrupts bring the processor back to run. Wait and doze accept any interrupt line. Stop accepts only the external lines. No recovery delay is inserted: run resumes on the cycle after the wake condition is seen. The clock source itself stays up in every state and is not part of this block.

All pins are plain control and status signals. The block has no data stream, so no valid/ready handshake applies. Interrupt inputs are level-sensitive vectors and are merged inside the block.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode output reads run (00), all three clock enables are 1, and the selector register holds 00.
- R2: A stop strobe seen in run changes the mode on the next clock edge. Selector 00 enters wait (mode output 01), 01 enters doze (mode output 10), and 10 enters stop (mode output 11).
- R3: Selector value 11 is reserved and a stop strobe with it enters wait (mode output 01).
- R4: In wait, the CPU/memory enable is 0 and both peripheral group enables are 1.
- R5: In doze, the CPU/memory enable and the group A enable are 0, and the group B enable is 1.
- R6: In stop, all three clock enables are 0.
- R7: In wait or doze, any set bit of either interrupt vector returns the mode to run on the next clock edge.
- R8: In stop, internal interrupts leave the mode unchanged, and any set external interrupt bit returns the mode to run on the next clock edge.
- R9: A selector write made during a sleep state does not change the current mode. The written value is used by the next stop strobe.
- R10: A stop strobe during a sleep state is ignored. Interrupts seen in run leave the mode in run.
- R11: When a selector write and a stop strobe occur in the same cycle, the strobe uses the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_we | input | 1 | Selector register write enable |
| sel_wdata | input | 2 | Selector value: 00 wait, 01 doze, 10 stop, 11 wait |
| stop_cmd | input | 1 | One-cycle stop command strobe |
| irq_int | input | N_INT | Internal interrupt request lines (level) |
| irq_ext | input | N_EXT | External interrupt request lines (level) |
| cpu_clk_en | output | 1 | CPU/memory clock enable |
| grp_a_clk_en | output | 1 | Peripheral group A clock enable (off in doze and stop) |
| grp_b_clk_en | output | 1 | Peripheral group B clock enable (off in stop only) |
| mode | output | 2 | Current mode: 00 run, 01 wait, 10 doze, 11 stop |

## Verification
Assertions check the following on every cycle:
- the mode after every edge matches the interrupt and strobe conditions of the cycle before, including stop ignoring internal lines;
- a stop strobe in run lands in the state decoded from the previously stored selector;
- the CPU enable rises only after an interrupt.

Some behaviours can only be shown by the directed scenarios. These include the reserved selector code, the exact enable pattern of each state as seen at the pins, a write made while asleep that first shows up at the following stop strobe, and the collision of a write with a strobe.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int SEL_W  = 2;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_RUN  = 2'b00,
    PM_WAIT = 2'b01,
    PM_DOZE = 2'b10,
    PM_STOP = 2'b11
  } pm_mode_e;

  // Map a selector value onto the sleep state it requests; 11 folds to wait.
  function automatic pm_mode_e sel_to_mode(input logic [SEL_W-1:0] sel);
    pm_mode_e m;
    case (sel)
      2'b01:   m = PM_DOZE;
      2'b10:   m = PM_STOP;
      default: m = PM_WAIT;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lpm_sel_reg.sv
module lpm_sel_reg
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] sel_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sel_q <= '0;
    else if (we) sel_q <= wdata;
  end

endmodule

// File: rtl/lpm_wake_merge.sv
module lpm_wake_merge #(
  parameter int N_INT = 4,
  parameter int N_EXT = 2
) (
  input  logic [N_INT-1:0] irq_int,
  input  logic [N_EXT-1:0] irq_ext,
  output logic             wake_any,
  output logic             wake_ext
);

  logic [N_EXT:0] ext_chain;
  assign ext_chain[0] = 1'b0;

  // Ripple OR written out per line so a wide external vector keeps a regular shape.
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign ext_chain[g+1] = ext_chain[g] | irq_ext[g];
  end

  assign wake_ext = ext_chain[N_EXT];
  assign wake_any = wake_ext | (|irq_int);

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_cmd,
  input  logic [SEL_W-1:0] sel_q,
  input  logic             wake_any,
  input  logic             wake_ext,
  output pm_mode_e         mode_q
);

  pm_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      PM_RUN:  if (stop_cmd) mode_d = sel_to_mode(sel_q);
      PM_WAIT,
      PM_DOZE: if (wake_any) mode_d = PM_RUN;
      PM_STOP: if (wake_ext) mode_d = PM_RUN;
      default: mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_RUN;
    else        mode_q <= mode_d;
  end

  AST_ENTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_RUN && stop_cmd) |=> (mode_q == sel_to_mode($past(sel_q)))); // R2

  AST_LIGHT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == PM_WAIT || mode_q == PM_DOZE) && wake_any) |=> (mode_q == PM_RUN)); // R7

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_STOP && !wake_ext) |=> (mode_q == PM_STOP)); // R8

  AST_STOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_STOP && wake_ext) |=> (mode_q == PM_RUN)); // R8

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_RUN && !stop_cmd) |=> (mode_q == PM_RUN)); // R10

endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate
  import lpm_pkg::*;
(
  input  pm_mode_e mode_q,
  output logic     cpu_en,
  output logic     grp_a_en,
  output logic     grp_b_en
);

  always_comb begin
    cpu_en   = 1'b0;
    grp_a_en = 1'b0;
    grp_b_en = 1'b0;
    unique case (mode_q)
      PM_RUN:  begin cpu_en = 1'b1; grp_a_en = 1'b1; grp_b_en = 1'b1; end
      PM_WAIT: begin grp_a_en = 1'b1; grp_b_en = 1'b1; end
      PM_DOZE: grp_b_en = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int N_INT = 4,
  parameter int N_EXT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [SEL_W-1:0]  sel_wdata,
  input  logic              stop_cmd,
  input  logic [N_INT-1:0]  irq_int,
  input  logic [N_EXT-1:0]  irq_ext,
  output logic              cpu_clk_en,
  output logic              grp_a_clk_en,
  output logic              grp_b_clk_en,
  output logic [MODE_W-1:0] mode
);

  logic [SEL_W-1:0] sel_q;
  logic             wake_any;
  logic             wake_ext;
  pm_mode_e         mode_q;

  lpm_sel_reg u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sel_we),
    .wdata (sel_wdata),
    .sel_q (sel_q)
  );

  lpm_wake_merge #(.N_INT(N_INT), .N_EXT(N_EXT)) u_wake (
    .irq_int  (irq_int),
    .irq_ext  (irq_ext),
    .wake_any (wake_any),
    .wake_ext (wake_ext)
  );

  lpm_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_cmd (stop_cmd),
    .sel_q    (sel_q),
    .wake_any (wake_any),
    .wake_ext (wake_ext),
    .mode_q   (mode_q)
  );

  lpm_clk_gate u_gate (
    .mode_q   (mode_q),
    .cpu_en   (cpu_clk_en),
    .grp_a_en (grp_a_clk_en),
    .grp_b_en (grp_b_clk_en)
  );

  assign mode = mode_q;

  AST_CPU_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> $past((|irq_int) || (|irq_ext))); // R7

  AST_STOP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == PM_STOP && !(|$past(irq_ext))) |-> !grp_b_clk_en); // R8

endmodule

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_we = 1'b0;
  logic [1:0] sel_wdata = '0;
  logic stop_cmd = 1'b0;
  logic [NI-1:0] irq_int = '0;
  logic [NE-1:0] irq_ext = '0;
  logic cpu_clk_en, grp_a_clk_en, grp_b_clk_en;
  logic [1:0] mode;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl #(.N_INT(NI), .N_EXT(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .stop_cmd(stop_cmd), .irq_int(irq_int), .irq_ext(irq_ext),
    .cpu_clk_en(cpu_clk_en), .grp_a_clk_en(grp_a_clk_en),
    .grp_b_clk_en(grp_b_clk_en), .mode(mode)
  );

  // Expected pins: {mode, cpu, grpA, grpB}
  task automatic expect_state(input logic [1:0] m, input logic c, input logic a,
                              input logic b, input string req);
    total++;
    if ({mode, cpu_clk_en, grp_a_clk_en, grp_b_clk_en} !== {m, c, a, b}) begin
      bad++;
      $display("FAIL %s: mode/cpu/a/b actual=%b/%b/%b/%b expected=%b/%b/%b/%b",
               req, mode, cpu_clk_en, grp_a_clk_en, grp_b_clk_en, m, c, a, b);
    end
  endtask

  // Inputs change on the falling edge; one edge later the outputs are read.
  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic write_sel(input logic [1:0] v);
    sel_we = 1'b1; sel_wdata = v; cycle(); sel_we = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_cmd = 1'b1; cycle(); stop_cmd = 1'b0;
  endtask

  task automatic t_reset();
    expect_state(2'b00, 1, 1, 1, "R1");
    pulse_stop();  // register must hold 00 -> wait
    expect_state(2'b01, 0, 1, 1, "R1");
    irq_int = 4'b0001; cycle(); irq_int = '0;
    expect_state(2'b00, 1, 1, 1, "R7");
  endtask

  task automatic t_wait();
    write_sel(2'b00); pulse_stop();
    expect_state(2'b01, 0, 1, 1, "R4");
    cycle();
    expect_state(2'b01, 0, 1, 1, "R2");
    irq_ext = 2'b10; cycle(); irq_ext = '0;
    expect_state(2'b00, 1, 1, 1, "R7");
  endtask

  task automatic t_doze();
    write_sel(2'b01); pulse_stop();
    expect_state(2'b10, 0, 0, 1, "R5");
    irq_int = 4'b1000; cycle(); irq_int = '0;
    expect_state(2'b00, 1, 1, 1, "R7");
  endtask

  task automatic t_stop();
    write_sel(2'b10); pulse_stop();
    expect_state(2'b11, 0, 0, 0, "R6");
    irq_int = 4'b1111; cycle(); cycle(); irq_int = '0;
    expect_state(2'b11, 0, 0, 0, "R8");
    irq_ext = 2'b01; cycle(); irq_ext = '0;
    expect_state(2'b00, 1, 1, 1, "R8");
  endtask

  task automatic t_reserved();
    write_sel(2'b11); pulse_stop();
    expect_state(2'b01, 0, 1, 1, "R3");
    irq_int = 4'b0100; cycle(); irq_int = '0;
    expect_state(2'b00, 1, 1, 1, "R3");
  endtask

  task automatic t_late_write();
    write_sel(2'b00); pulse_stop();
    expect_state(2'b01, 0, 1, 1, "R9");
    write_sel(2'b10);
    expect_state(2'b01, 0, 1, 1, "R9");
    irq_int = 4'b0010; cycle(); irq_int = '0;
    pulse_stop();
    expect_state(2'b11, 0, 0, 0, "R9");
    irq_ext = 2'b11; cycle(); irq_ext = '0;
    expect_state(2'b00, 1, 1, 1, "R9");
  endtask

  task automatic t_ignore();
    irq_int = 4'b0011; irq_ext = 2'b01; cycle(); irq_int = '0; irq_ext = '0;
    expect_state(2'b00, 1, 1, 1, "R10");
    write_sel(2'b01); pulse_stop();
    write_sel(2'b10); pulse_stop();  // strobe while dozing must be ignored
    expect_state(2'b10, 0, 0, 1, "R10");
    irq_ext = 2'b01; cycle(); irq_ext = '0;
    expect_state(2'b00, 1, 1, 1, "R10");
  endtask

  task automatic t_collide();
    write_sel(2'b01);
    sel_we = 1'b1; sel_wdata = 2'b10; stop_cmd = 1'b1; cycle();
    sel_we = 1'b0; stop_cmd = 1'b0;
    expect_state(2'b10, 0, 0, 1, "R11");
    irq_int = 4'b0001; cycle(); irq_int = '0;
    pulse_stop();  // now the new value 10 applies
    expect_state(2'b11, 0, 0, 0, "R11");
    irq_ext = 2'b10; cycle(); irq_ext = '0;
  endtask

  initial begin
    repeat (3) cycle();
    rst_n = 1'b1;
    cycle();
    t_reset();
    t_wait();
    t_doze();
    t_stop();
    t_reserved();
    t_late_write();
    t_ignore();
    t_collide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule